// File: doc/BRIEF.md
# Dual-Channel Serial Line Monitor

This block listens, without driving anything, to the two directions of an asynchronous serial link: the receive line and the transmit line. Both lines are sampled on clock cycles that have the shared sample enable set. Each line has its own frame decoder. A decoder finds the leading edge of a frame and samples every bit slot at its centre. It rebuilds the data word in the configured bit order, then checks the parity bit and the stop bit.

For every field it decodes, the block reports a small event record: the channel, a 3-bit event code and a 9-bit value. The two channels share one output port. When both channels report on the same sample, the receive event comes out first and the transmit event follows on the next clock. Software-free runtime inputs set the bit period in samples, the data width, the parity mode and the bit order. These inputs are expected to change only while both lines are idle.

Top module: `uart_mon_top`

## Requirements
- R1: A channel waiting for a frame starts one only on a 1-to-0 change between two consecutive enabled samples of its line. The first enabled sample after reset only records the line level, so it can never start a frame.
- R2: The sample where the edge is seen has relative index 0. Bit slot n (0 = start, 1..N = data, then parity or stop) is sampled at relative index floor(P/2) + n*P, where P = `cfg_period_i` and P must be at least 2. Relative indices count enabled samples only.
- R3: `cfg_width_i` selects N data bits, from 5 to 9. After the last data bit, a DATA event (code 1) carries the word zero-extended to 9 bits.
- R4: With `cfg_msb_first_i` = 0, the first data bit received is bit 0 of the word. With 1, the first data bit received is bit N-1.
- R5: Parity modes on `cfg_parity_i` are: 1 = bit must be 0, 2 = bit must be 1, 3 = odd count of ones over data and parity bit, 4 = even count. The result is PAR_OK (code 2) or PAR_ERR (code 3), and the value is the parity bit.
- R6: With `cfg_parity_i` = 0 there is no parity slot and no parity event. The stop bit is sampled at slot N+1 instead of N+2.
- R7: A start bit sampled as 0 gives START (code 0, value 0). A start bit sampled as 1 gives BAD_START (code 5, value 1) in place of START, and decoding of the frame carries on unchanged.
- R8: The single stop bit gives STOP (code 4, value 1) or BAD_STOP (code 6, value 0). Either way the channel goes back to waiting for a frame.
- R9: The channels decode independently. `evt_chan_o` is 0 for receive events and 1 for transmit events.
- R10: When both channels emit an event on the same sample, the receive event is presented on one clock and the transmit event on the following clock.
- R11: While `rst_ni` is low, and after reset until a decoded field exists, `evt_valid_o` is 0.
- R12: Cycles with `sample_en_i` low change no decoding state, whatever the lines do during them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_en_i | input | 1 | Marks the cycles on which both lines are sampled |
| rx_i | input | 1 | Receive line (channel 0) |
| tx_i | input | 1 | Transmit line (channel 1) |
| cfg_period_i | input | 16 | Bit period in samples, 2 or more |
| cfg_width_i | input | 4 | Data bits per frame, 5 to 9 |
| cfg_parity_i | input | 3 | Parity mode, 0 to 4 |
| cfg_msb_first_i | input | 1 | 1 = most significant data bit first |
| evt_valid_o | output | 1 | Event record valid for this clock |
| evt_chan_o | output | 1 | Channel of the event |
| evt_code_o | output | 3 | Event code |
| evt_value_o | output | 9 | Event value |

## Verification
The bench builds the block with its default parameters: a 16-bit period count and a 9-bit word. All data widths from 5 to 9 bits and every parity mode can therefore be reached.

Runtime periods are kept between 4 and 11 samples, so many frames fit in a short run. In the generated waveforms, only the centre sample of each bit slot carries the true bit and every other sample carries its complement. Any error in the mid-bit position therefore corrupts the decoded fields. Random bursts of disabled cycles with toggling lines test R12, and identical frames on both lines test the same-sample ordering.

// File: rtl/uart_mon_pkg.sv
package uart_mon_pkg;
  typedef enum logic [2:0] {
    EV_START     = 3'd0,
    EV_DATA      = 3'd1,
    EV_PAR_OK    = 3'd2,
    EV_PAR_ERR   = 3'd3,
    EV_STOP      = 3'd4,
    EV_BAD_START = 3'd5,
    EV_BAD_STOP  = 3'd6
  } evt_code_e;

  typedef enum logic [2:0] {
    PAR_NONE  = 3'd0,
    PAR_SPACE = 3'd1,
    PAR_MARK  = 3'd2,
    PAR_ODD   = 3'd3,
    PAR_EVEN  = 3'd4
  } par_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } chan_st_e;
endpackage

// File: rtl/uart_mon_chan.sv
module uart_mon_chan
  import uart_mon_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int WORD_W   = 9,
  localparam int WIDTH_W = $clog2(WORD_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_en_i,
  input  logic                line_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic [WIDTH_W-1:0]  width_i,
  input  logic [2:0]          parity_i,
  input  logic                msb_first_i,
  output logic                evt_v_o,
  output logic [2:0]          evt_code_o,
  output logic [WORD_W-1:0]   evt_val_o
);
  chan_st_e            st_q;
  logic                init_q, prev_q;
  logic [PERIOD_W-1:0] cd_q;
  logic [WIDTH_W-1:0]  nbit_q;
  logic [WORD_W-1:0]   word_q, word_nxt;
  logic                par_good;
  logic [PERIOD_W-1:0] half;

  assign half = period_i >> 1;

  always_comb begin
    if (msb_first_i) word_nxt = {word_q[WORD_W-2:0], line_i};
    else word_nxt = (word_q >> 1) | (WORD_W'(line_i) << (width_i - 1'b1));
  end

  always_comb begin
    case (par_mode_e'(parity_i))
      PAR_SPACE: par_good = !line_i;
      PAR_MARK:  par_good = line_i;
      PAR_ODD:   par_good = ^{word_q, line_i};
      PAR_EVEN:  par_good = !(^{word_q, line_i});
      default:   par_good = 1'b1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      init_q     <= 1'b0;
      prev_q     <= 1'b1;
      cd_q       <= '0;
      nbit_q     <= '0;
      word_q     <= '0;
      evt_v_o    <= 1'b0;
      evt_code_o <= 3'd0;
      evt_val_o  <= '0;
    end else begin
      evt_v_o <= 1'b0;
      if (sample_en_i) begin
        init_q <= 1'b1;
        prev_q <= line_i;
        if (st_q == ST_IDLE) begin
          if (init_q && prev_q && !line_i) begin
            st_q <= ST_START;
            cd_q <= half;
          end
        end else if (cd_q == PERIOD_W'(1)) begin
          cd_q <= period_i;
          case (st_q)
            ST_START: begin
              evt_v_o    <= 1'b1;
              evt_code_o <= line_i ? EV_BAD_START : EV_START;
              evt_val_o  <= WORD_W'(line_i);
              word_q     <= '0;
              nbit_q     <= '0;
              st_q       <= ST_DATA;
            end
            ST_DATA: begin
              word_q <= word_nxt;
              if (nbit_q == width_i - 1'b1) begin
                evt_v_o    <= 1'b1;
                evt_code_o <= EV_DATA;
                evt_val_o  <= word_nxt;
                st_q       <= (par_mode_e'(parity_i) == PAR_NONE) ? ST_STOP : ST_PAR;
              end else begin
                nbit_q <= nbit_q + 1'b1;
              end
            end
            ST_PAR: begin
              evt_v_o    <= 1'b1;
              evt_code_o <= par_good ? EV_PAR_OK : EV_PAR_ERR;
              evt_val_o  <= WORD_W'(line_i);
              st_q       <= ST_STOP;
            end
            ST_STOP: begin
              evt_v_o    <= 1'b1;
              evt_code_o <= line_i ? EV_STOP : EV_BAD_STOP;
              evt_val_o  <= WORD_W'(line_i);
              st_q       <= ST_IDLE;
            end
            default: st_q <= ST_IDLE;
          endcase
        end else begin
          cd_q <= cd_q - 1'b1;
        end
      end
    end
  end

  // R1: leaving idle needs an enabled falling edge seen after the first sample
  assert_stay_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_IDLE && !(sample_en_i && init_q && prev_q && !line_i)) |=> st_q == ST_IDLE);

  assert_data_fits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_v_o && evt_code_o == EV_DATA) |-> (evt_val_o >> width_i) == '0);

  assert_stop_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_v_o && (evt_code_o == EV_STOP || evt_code_o == EV_BAD_STOP)) |-> st_q == ST_IDLE);

  assert_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> ($stable(st_q) && $stable(word_q) && $stable(cd_q) && !evt_v_o));
endmodule

// File: rtl/uart_mon_arb.sv
module uart_mon_arb #(
  parameter int WORD_W = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_v_i,
  input  logic [2:0]        rx_code_i,
  input  logic [WORD_W-1:0] rx_val_i,
  input  logic              tx_v_i,
  input  logic [2:0]        tx_code_i,
  input  logic [WORD_W-1:0] tx_val_i,
  output logic              evt_valid_o,
  output logic              evt_chan_o,
  output logic [2:0]        evt_code_o,
  output logic [WORD_W-1:0] evt_value_o
);
  logic              pend_v_q;
  logic [2:0]        pend_code_q;
  logic [WORD_W-1:0] pend_val_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_valid_o <= 1'b0;
      evt_chan_o  <= 1'b0;
      evt_code_o  <= 3'd0;
      evt_value_o <= '0;
      pend_v_q    <= 1'b0;
      pend_code_q <= 3'd0;
      pend_val_q  <= '0;
    end else begin
      evt_valid_o <= rx_v_i || pend_v_q || tx_v_i;
      if (rx_v_i) begin
        evt_chan_o  <= 1'b0;
        evt_code_o  <= rx_code_i;
        evt_value_o <= rx_val_i;
      end else if (pend_v_q) begin
        evt_chan_o  <= 1'b1;
        evt_code_o  <= pend_code_q;
        evt_value_o <= pend_val_q;
      end else if (tx_v_i) begin
        evt_chan_o  <= 1'b1;
        evt_code_o  <= tx_code_i;
        evt_value_o <= tx_val_i;
      end
      // transmit event waits one slot when the port is taken
      if (tx_v_i && (rx_v_i || pend_v_q)) begin
        pend_v_q    <= 1'b1;
        pend_code_q <= tx_code_i;
        pend_val_q  <= tx_val_i;
      end else if (!rx_v_i) begin
        pend_v_q <= 1'b0;
      end
    end
  end

  assert_rx_first_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_v_i |=> (evt_valid_o && !evt_chan_o));

  assert_tx_next_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_v_i && tx_v_i) |=> (evt_valid_o && !evt_chan_o) ##1 (evt_valid_o && evt_chan_o));
endmodule

// File: rtl/uart_mon_top.sv
module uart_mon_top
  import uart_mon_pkg::*;
#(
  parameter int PERIOD_W = 16,
  parameter int WORD_W   = 9,
  localparam int WIDTH_W = $clog2(WORD_W + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sample_en_i,
  input  logic                rx_i,
  input  logic                tx_i,
  input  logic [PERIOD_W-1:0] cfg_period_i,
  input  logic [WIDTH_W-1:0]  cfg_width_i,
  input  logic [2:0]          cfg_parity_i,
  input  logic                cfg_msb_first_i,
  output logic                evt_valid_o,
  output logic                evt_chan_o,
  output logic [2:0]          evt_code_o,
  output logic [WORD_W-1:0]   evt_value_o
);
  localparam int NCH = 2;

  logic [NCH-1:0]    lines;
  logic [NCH-1:0]    ch_v;
  logic [2:0]        ch_code [NCH];
  logic [WORD_W-1:0] ch_val  [NCH];

  assign lines = {tx_i, rx_i};

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    uart_mon_chan #(.PERIOD_W(PERIOD_W), .WORD_W(WORD_W)) chan_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sample_en_i (sample_en_i),
      .line_i      (lines[c]),
      .period_i    (cfg_period_i),
      .width_i     (cfg_width_i),
      .parity_i    (cfg_parity_i),
      .msb_first_i (cfg_msb_first_i),
      .evt_v_o     (ch_v[c]),
      .evt_code_o  (ch_code[c]),
      .evt_val_o   (ch_val[c])
    );
  end

  uart_mon_arb #(.WORD_W(WORD_W)) arb_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rx_v_i      (ch_v[0]),
    .rx_code_i   (ch_code[0]),
    .rx_val_i    (ch_val[0]),
    .tx_v_i      (ch_v[1]),
    .tx_code_i   (ch_code[1]),
    .tx_val_i    (ch_val[1]),
    .evt_valid_o (evt_valid_o),
    .evt_chan_o  (evt_chan_o),
    .evt_code_o  (evt_code_o),
    .evt_value_o (evt_value_o)
  );

  assert_no_reset_evt_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !evt_valid_o);
endmodule

// File: tb/uart_mon_top_tb_top.sv
module uart_mon_top_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, rx = 1'b1, tx = 1'b1;
  logic [15:0] period = 16'd8;
  logic [3:0]  width = 4'd8;
  logic [2:0]  par = 3'd0;
  logic        msb = 1'b0;
  logic        ev_v, ev_ch;
  logic [2:0]  ev_code;
  logic [8:0]  ev_val;

  int total = 0, fails = 0, cyc = 0;
  bit done = 1'b0;

  bit rxw[$], txw[$];
  int exp_rx[$], exp_tx[$], act_rx[$], act_tx[$], cyc_rx[$], cyc_tx[$];

  always #5 clk = ~clk;

  uart_mon_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sample_en_i(en), .rx_i(rx), .tx_i(tx),
    .cfg_period_i(period), .cfg_width_i(width), .cfg_parity_i(par),
    .cfg_msb_first_i(msb), .evt_valid_o(ev_v), .evt_chan_o(ev_ch),
    .evt_code_o(ev_code), .evt_value_o(ev_val)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n && ev_v) begin
      if (!ev_ch) begin act_rx.push_back({ev_code, 16'(ev_val)}); cyc_rx.push_back(cyc); end
      else begin act_tx.push_back({ev_code, 16'(ev_val)}); cyc_tx.push_back(cyc); end
    end
  end

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit par_ok(int mode, int data, int pb);
    int c = $countones(data) + pb;
    case (mode)
      1: return pb == 0;
      2: return pb == 1;
      3: return (c % 2) == 1;
      default: return (c % 2) == 0;
    endcase
  endfunction

  function automatic string req_of(int code);
    case (code)
      0, 5: return "R7";
      1: return msb ? "R4" : "R2/R3";
      2, 3: return "R5";
      default: return "R8";
    endcase
  endfunction

  task automatic push_w(int ch, bit v);
    if (ch == 0) rxw.push_back(v); else txw.push_back(v);
  endtask

  task automatic push_e(int ch, int code, int val);
    if (ch == 0) exp_rx.push_back((code << 16) | val); else exp_tx.push_back((code << 16) | val);
  endtask

  // Only the centre sample of each slot carries the bit; the rest carry its inverse
  task automatic add_frame(int ch, int data, bit bad_start, bit bad_par, bit bad_stop, int gap);
    bit slots[$];
    int p = int'(period), w = int'(width), hf = int'(period) / 2;
    int pb = 0;
    slots.push_back(bad_start);
    for (int i = 0; i < w; i++) slots.push_back(((data >> (msb ? (w - 1 - i) : i)) & 1) != 0);
    if (par != 0) begin
      if (!par_ok(int'(par), data, 0)) pb = 1;
      pb = pb ^ int'(bad_par);
      slots.push_back(pb[0]);
    end
    slots.push_back(!bad_stop);
    repeat (gap) push_w(ch, 1'b1);
    for (int s = 0; s < slots.size(); s++)
      for (int k = 0; k < p; k++) begin
        bit v = (k == hf) ? slots[s] : !slots[s];
        if (s == 0 && k == 0) v = 1'b0;
        if (s == slots.size() - 1 && k > hf) v = 1'b1;
        push_w(ch, v);
      end
    push_e(ch, bad_start ? 5 : 0, bad_start ? 1 : 0);
    push_e(ch, 1, data);
    if (par != 0) push_e(ch, par_ok(int'(par), data, pb) ? 2 : 3, pb);
    push_e(ch, bad_stop ? 6 : 4, bad_stop ? 0 : 1);
  endtask

  task automatic step(bit r, bit t, int gap);
    rx = r; tx = t; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    repeat (gap) begin
      rx = 1'($urandom); tx = 1'($urandom);
      @(negedge clk);
    end
    rx = 1'b1; tx = 1'b1;
  endtask

  task automatic play(int maxgap);
    while (rxw.size() < txw.size()) rxw.push_back(1'b1);
    while (txw.size() < rxw.size()) txw.push_back(1'b1);
    repeat (3) begin rxw.push_back(1'b1); txw.push_back(1'b1); end
    for (int i = 0; i < rxw.size(); i++)
      step(rxw[i], txw[i], (maxgap > 0) ? int'($urandom_range(0, maxgap)) : 0);
    rxw.delete(); txw.delete();
    repeat (4) @(negedge clk);
  endtask

  task automatic check_block(string tag);
    chk(act_rx.size() == exp_rx.size(), {tag, " rx event count"}, act_rx.size(), exp_rx.size());
    chk(act_tx.size() == exp_tx.size(), {tag, " R9 tx event count"}, act_tx.size(), exp_tx.size());
    for (int i = 0; i < act_rx.size() && i < exp_rx.size(); i++)
      chk(act_rx[i] == exp_rx[i], req_of(exp_rx[i] >> 16), act_rx[i], exp_rx[i]);
    for (int i = 0; i < act_tx.size() && i < exp_tx.size(); i++)
      chk(act_tx[i] == exp_tx[i], req_of(exp_tx[i] >> 16), act_tx[i], exp_tx[i]);
    act_rx.delete(); act_tx.delete(); exp_rx.delete(); exp_tx.delete();
    cyc_rx.delete(); cyc_tx.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(ev_v == 1'b0, "R11 valid in reset", int'(ev_v), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ev_v == 1'b0, "R11 valid after reset", int'(ev_v), 0);

    // R1: first sample low after a high reset level is not an edge
    repeat (20) step(1'b0, 1'b0, 0);
    repeat (10) step(1'b1, 1'b1, 0);
    repeat (4) @(negedge clk);
    chk(act_rx.size() + act_tx.size() == 0, "R1 no frame on first sample", act_rx.size() + act_tx.size(), 0);
    period = 16'd6; width = 4'd8; par = 3'd0; msb = 1'b0;
    add_frame(0, 8'hA5, 1'b0, 1'b0, 1'b0, 2);
    add_frame(1, 8'h3C, 1'b0, 1'b0, 1'b0, 5);
    play(0);
    check_block("R1");

    // R10: identical frames on both lines collide every event
    period = 16'd7; width = 4'd9; par = 3'd4; msb = 1'b0;
    add_frame(0, 9'h15B, 1'b0, 1'b0, 1'b0, 2);
    add_frame(1, 9'h15B, 1'b0, 1'b0, 1'b0, 2);
    add_frame(0, 9'h0F0, 1'b1, 1'b1, 1'b1, 1);
    add_frame(1, 9'h0F0, 1'b1, 1'b1, 1'b1, 1);
    play(0);
    chk(cyc_rx.size() == cyc_tx.size(), "R10 pair count", cyc_rx.size(), cyc_tx.size());
    for (int i = 0; i < cyc_rx.size() && i < cyc_tx.size(); i++) begin
      chk(cyc_tx[i] == cyc_rx[i] + 1, "R10 tx one clock after rx", cyc_tx[i], cyc_rx[i] + 1);
      chk(act_tx[i] == act_rx[i], "R10 same record", act_tx[i], act_rx[i]);
    end
    check_block("R10");

    for (int blk = 0; blk < 12; blk++) begin
      int maxgap = blk % 3;
      period = 16'(4 + ($urandom % 8));
      width  = 4'(5 + ($urandom % 5));
      par    = (blk < 5) ? 3'(blk) : 3'($urandom % 5);
      msb    = blk[0];
      for (int f = 0; f < 5; f++)
        for (int ch = 0; ch < 2; ch++)
          add_frame(ch, int'($urandom) & ((1 << int'(width)) - 1),
                    ($urandom % 6) == 0, ($urandom % 4) == 0, ($urandom % 6) == 0,
                    int'($urandom % 4));
      play(maxgap);
      check_block((par == 0) ? "R6" : ((maxgap > 0) ? "R12" : "R9"));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule